// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block finds read-after-write hazards in a five-stage in-order pipeline that has no bypass paths. The stages are fetch, decode, execute, memory and write-back. The block looks at the instruction word in decode and works out which source registers that word reads. It also looks at the words in execute, memory and write-back and works out which register each of them will write. When a source that is read matches a pending destination that is enabled for writing, the block raises `stall_o`. While stall is high, fetch and decode keep their contents and an all-zero no-op enters execute.

Each word is decoded by opcode, so a field that merely happens to hold a matching register number does not cause a stall. The destination can be taken from rd, from rt, or from the fixed link register 31. A source port counts only when the opcode actually reads it. The block also contains a small harness of pipeline registers. It moves words from the fetch input through decode, execute, memory and write-back, so the interlock can be driven and observed as it runs in a pipeline.

Field positions: op is bits [31:26], rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11].

Top module: `hz_interlock_unit`

## Requirements
- R1: While `rst_n` is low, the decode, execute, memory and write-back words are all zero (no-op bubbles), and `stall_o` is low once the reset has taken effect.
- R2: The destination register depends on the opcode. Opcode 0x00 (register ALU) writes rd. Opcodes 0x08–0x0F (immediate ALU) and 0x23 (load) write rt. Opcodes 0x03 (jump-and-link) and 0x17 (jump-and-link via register) write register 31.
- R3: A write counts only when it is enabled. Register ALU, immediate ALU and load are enabled only when their destination is not zero. Both link opcodes are always enabled. Every other opcode, including store 0x2B and branch-on-zero 0x04/0x05, never writes, so it never triggers a stall.
- R4: The first source (rs) is read by opcode 0x00, 0x08–0x0F, 0x23, 0x2B, 0x04, 0x05, 0x16 (jump via register) and 0x17. It is not read by 0x02 (jump) or 0x03.
- R5: The second source (rt) is read only by opcode 0x00 and opcode 0x2B.
- R6: `stall_o` is high exactly when a source read by the decode word equals the enabled destination of the word in execute, memory or write-back.
- R7: In a stalled cycle, decode keeps its word and execute receives the word 0x00000000, while memory and write-back keep advancing. In a cycle without a stall, every stage takes the word from the stage before it.
- R8: A consumer that follows its producer directly stalls for 3 cycles. With one unrelated word between them it stalls for 2 cycles, with two between them for 1 cycle, and with three between them it does not stall.
- R9: An injected bubble never causes a further stall. A pipeline that holds only bubbles never stalls.
- R10: A store followed by a load from the same memory address causes no stall, because the memory completes each write in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pipeline registers update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; fills every stage with a bubble |
| fetch_word_i | input | 32 | Instruction word offered by fetch; the fetch source must hold it while `stall_o` is high |
| stall_o | output | 1 | Interlock request: holds fetch and decode and puts a bubble into execute |
| dec_word_o | output | 32 | Word held in the decode stage |
| exe_word_o | output | 32 | Word held in the execute stage |
| wb_word_o | output | 32 | Word held in the write-back stage |

## Verification
The bench builds the block with its default geometry: 32-bit words, 5-bit register fields and three later stages compared against decode. With these settings, every distance between producer and consumer from zero to three is reachable, so the full 3/2/1/0 stall profile can be observed at the ports. Directed programs test each opcode class both as a producer and as a consumer. Some words place a matching register number in a field that the opcode ignores, which probes the false-stall suppression. A behavioural model written as a set of stage variables is compared with the stall output and with the decode, execute and write-back words on every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_AW  = 5;
    localparam int OP_W    = 6;
    localparam int OP_LSB  = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;
    localparam int N_LATER = 3;

    localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(31);

    localparam logic [OP_W-1:0] OP_REG  = 6'h00;
    localparam logic [OP_W-1:0] OP_J    = 6'h02;
    localparam logic [OP_W-1:0] OP_JAL  = 6'h03;
    localparam logic [OP_W-1:0] OP_BZ0  = 6'h04;
    localparam logic [OP_W-1:0] OP_BZ1  = 6'h05;
    localparam logic [OP_W-1:0] OP_JR   = 6'h16;
    localparam logic [OP_W-1:0] OP_JALR = 6'h17;
    localparam logic [OP_W-1:0] OP_LD   = 6'h23;
    localparam logic [OP_W-1:0] OP_ST   = 6'h2B;

    typedef enum logic [3:0] {
        CLS_REG, CLS_IMM, CLS_LD, CLS_ST, CLS_BZ,
        CLS_J, CLS_JAL, CLS_JR, CLS_JALR, CLS_OTHER
    } op_class_t;

    typedef struct packed {
        logic [WORD_W-1:0] dec;
        logic [WORD_W-1:0] exe;
        logic [WORD_W-1:0] mem;
        logic [WORD_W-1:0] wb;
    } pipe_t;

    function automatic op_class_t classify(logic [OP_W-1:0] op);
        op_class_t c;
        if (op[OP_W-1:3] == 3'b001) begin
            c = CLS_IMM;
        end else begin
            case (op)
                OP_REG:         c = CLS_REG;
                OP_LD:          c = CLS_LD;
                OP_ST:          c = CLS_ST;
                OP_BZ0, OP_BZ1: c = CLS_BZ;
                OP_J:           c = CLS_J;
                OP_JAL:         c = CLS_JAL;
                OP_JR:          c = CLS_JR;
                OP_JALR:        c = CLS_JALR;
                default:        c = CLS_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/hz_dst_decode.sv
module hz_dst_decode
    import hz_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [REG_AW-1:0] rt_i,
    input  logic [REG_AW-1:0] rd_i,
    output logic [REG_AW-1:0] ws_o,
    output logic              we_o
);

    op_class_t cls;

    always_comb begin
        cls  = classify(op_i);
        ws_o = '0;
        we_o = 1'b0;
        case (cls)
            CLS_REG: begin
                ws_o = rd_i;
                we_o = |rd_i;
            end
            CLS_IMM, CLS_LD: begin
                ws_o = rt_i;
                we_o = |rt_i;
            end
            CLS_JAL, CLS_JALR: begin
                ws_o = LINK_REG;
                we_o = 1'b1;
            end
            default: begin
                ws_o = '0;
                we_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hz_src_decode.sv
module hz_src_decode
    import hz_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic            re1_o,
    output logic            re2_o
);

    op_class_t cls;

    always_comb begin
        cls   = classify(op_i);
        re1_o = 1'b0;
        re2_o = 1'b0;
        case (cls)
            CLS_REG, CLS_ST: begin
                re1_o = 1'b1;
                re2_o = 1'b1;
            end
            CLS_IMM, CLS_LD, CLS_BZ, CLS_JR, CLS_JALR: begin
                re1_o = 1'b1;
            end
            default: begin
                re1_o = 1'b0;
                re2_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hz_match.sv
module hz_match #(
    parameter int N  = 3,
    parameter int AW = 5
) (
    input  logic [AW-1:0]        src_i,
    input  logic                 re_i,
    input  logic [N-1:0][AW-1:0] ws_i,
    input  logic [N-1:0]         we_i,
    output logic                 hit_o
);

    logic [N-1:0] per_stage;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign per_stage[g] = we_i[g] && (ws_i[g] == src_i);
    end

    assign hit_o = re_i && (|per_stage);

endmodule

// File: rtl/hz_interlock_unit.sv
module hz_interlock_unit
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fetch_word_i,
    output logic              stall_o,
    output logic [WORD_W-1:0] dec_word_o,
    output logic [WORD_W-1:0] exe_word_o,
    output logic [WORD_W-1:0] wb_word_o
);

    pipe_t st_d, st_q;

    logic [N_LATER-1:0][WORD_W-1:0] later_w;
    logic [N_LATER-1:0][REG_AW-1:0] later_ws;
    logic [N_LATER-1:0]             later_we;
    logic [WORD_W-1:0]              mem_word;
    logic                           re1, re2, hit_rs, hit_rt;

    assign later_w[0] = st_q.exe;
    assign later_w[1] = st_q.mem;
    assign later_w[2] = st_q.wb;
    assign mem_word   = st_q.mem;

    for (genvar g = 0; g < N_LATER; g++) begin : g_dst
        hz_dst_decode u_dst (
            .op_i (later_w[g][OP_LSB +: OP_W]),
            .rt_i (later_w[g][RT_LSB +: REG_AW]),
            .rd_i (later_w[g][RD_LSB +: REG_AW]),
            .ws_o (later_ws[g]),
            .we_o (later_we[g])
        );
    end

    hz_src_decode u_src (
        .op_i  (st_q.dec[OP_LSB +: OP_W]),
        .re1_o (re1),
        .re2_o (re2)
    );

    hz_match #(.N(N_LATER), .AW(REG_AW)) u_match_rs (
        .src_i (st_q.dec[RS_LSB +: REG_AW]),
        .re_i  (re1),
        .ws_i  (later_ws),
        .we_i  (later_we),
        .hit_o (hit_rs)
    );

    hz_match #(.N(N_LATER), .AW(REG_AW)) u_match_rt (
        .src_i (st_q.dec[RT_LSB +: REG_AW]),
        .re_i  (re2),
        .ws_i  (later_ws),
        .we_i  (later_we),
        .hit_o (hit_rt)
    );

    assign stall_o = hit_rs | hit_rt;

    always_comb begin
        st_d     = st_q;
        st_d.wb  = st_q.mem;
        st_d.mem = st_q.exe;
        if (stall_o) begin
            st_d.dec = st_q.dec;
            st_d.exe = '0;
        end else begin
            st_d.dec = fetch_word_i;
            st_d.exe = st_q.dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_word_o = st_q.dec;
    assign exe_word_o = st_q.exe;
    assign wb_word_o  = st_q.wb;

endmodule

// File: rtl/hz_interlock_checker.sv
module hz_interlock_checker
    import hz_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stall_o,
    input logic [WORD_W-1:0] dec_word_o,
    input logic [WORD_W-1:0] exe_word_o,
    input logic [WORD_W-1:0] wb_word_o,
    input logic [WORD_W-1:0] mem_word
);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (dec_word_o == '0 && exe_word_o == '0 && wb_word_o == '0));

    assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (exe_word_o == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (dec_word_o == $past(dec_word_o)));

    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |=> (exe_word_o == $past(dec_word_o)));

    assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (wb_word_o == $past(mem_word)));

    assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (dec_word_o != '0));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_word_o == '0 && mem_word == '0 && wb_word_o == '0) |-> !stall_o);

endmodule

bind hz_interlock_unit hz_interlock_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_o    (stall_o),
    .dec_word_o (dec_word_o),
    .exe_word_o (exe_word_o),
    .wb_word_o  (wb_word_o),
    .mem_word   (mem_word)
);

// File: tb/hz_interlock_unit_test.sv
module hz_interlock_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word = 32'h0;
    logic        stall;
    logic [31:0] dec_w, exe_w, wb_w;

    int checks = 0;
    int errors = 0;
    logic [31:0] prog[$];
    logic [31:0] m_dec, m_exe, m_mem, m_wb;

    always #5 clk = ~clk;

    hz_interlock_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_word_i (fetch_word),
        .stall_o      (stall),
        .dec_word_o   (dec_w),
        .exe_word_o   (exe_w),
        .wb_word_o    (wb_w)
    );

    function automatic logic [31:0] rr(int rd, int rs, int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 11'h020};
    endfunction

    function automatic logic [31:0] ii(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic int dest_of(logic [31:0] w);
        int op = int'(w[31:26]);
        int rt = int'(w[20:16]);
        int rd = int'(w[15:11]);
        if (op == 0) return (rd == 0) ? -1 : rd;
        if ((op >= 8 && op <= 15) || op == 'h23) return (rt == 0) ? -1 : rt;
        if (op == 3 || op == 'h17) return 31;
        return -1;
    endfunction

    function automatic bit reads_a(logic [31:0] w);
        int op = int'(w[31:26]);
        return op == 0 || (op >= 8 && op <= 15) || op == 'h23 || op == 'h2B
            || op == 4 || op == 5 || op == 'h16 || op == 'h17;
    endfunction

    function automatic bit reads_b(logic [31:0] w);
        int op = int'(w[31:26]);
        return op == 0 || op == 'h2B;
    endfunction

    function automatic bit model_stall();
        logic [31:0] later[3];
        int rs = int'(m_dec[25:21]);
        int rt = int'(m_dec[20:16]);
        later[0] = m_exe; later[1] = m_mem; later[2] = m_wb;
        foreach (later[k]) begin
            int d = dest_of(later[k]);
            if (d >= 0 && ((reads_a(m_dec) && rs == d) || (reads_b(m_dec) && rt == d)))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_prog(string name, int exp_stalls);
        int pc = 0;
        int stalls = 0;
        bit ms;
        rst_n = 1'b0;
        fetch_word = 32'h0;
        m_dec = 0; m_exe = 0; m_mem = 0; m_wb = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset stall", {31'h0, stall}, 32'h0);
        check("R1 reset decode", dec_w, 32'h0);
        check("R1 reset execute", exe_w, 32'h0);
        check("R1 reset writeback", wb_w, 32'h0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 16; cyc++) begin
            fetch_word = (pc < prog.size()) ? prog[pc] : 32'h0;
            ms = model_stall();
            check("R6 stall", {31'h0, stall}, {31'h0, ms});
            check("R7 decode word", dec_w, m_dec);
            check("R7 execute word", exe_w, m_exe);
            check("R7 writeback word", wb_w, m_wb);
            if (ms) stalls++;
            m_wb = m_mem;
            m_mem = m_exe;
            if (ms) begin
                m_exe = 32'h0;
            end else begin
                m_exe = m_dec;
                m_dec = fetch_word;
                pc++;
            end
            @(negedge clk);
        end
        check(name, stalls, exp_stalls);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8 R9: back-to-back dependence; bubbles must not extend the stall
        prog = '{rr(1, 2, 3), rr(4, 1, 0)};
        run_prog("R8 R9 distance 1 stall count", 3);
        prog = '{rr(1, 2, 3), rr(9, 0, 0), rr(4, 1, 0)};
        run_prog("R8 distance 2 stall count", 2);
        prog = '{rr(1, 2, 3), rr(9, 0, 0), rr(10, 0, 0), rr(4, 1, 0)};
        run_prog("R8 distance 3 stall count", 1);
        prog = '{rr(1, 2, 3), rr(9, 0, 0), rr(10, 0, 0), rr(11, 0, 0), rr(4, 1, 0)};
        run_prog("R8 distance 4 stall count", 0);
        // R5: store reads rt produced by immediate ALU
        prog = '{ii(6'h08, 0, 2, 5), ii(6'h2B, 0, 2, 0)};
        run_prog("R5 store rt dependence", 3);
        // R5: immediate ALU rt is a destination, not a source
        prog = '{ii(6'h08, 0, 6, 1), ii(6'h09, 0, 6, 2)};
        run_prog("R5 immediate rt not read", 0);
        // R3: write to r0 is not enabled
        prog = '{rr(0, 1, 1), rr(5, 0, 0)};
        run_prog("R3 zero destination", 0);
        // R3: a store writes no register
        prog = '{ii(6'h2B, 0, 7, 0), rr(8, 7, 7)};
        run_prog("R3 store no write", 0);
        // R2: link register destination
        prog = '{{6'h03, 26'h10}, rr(6, 31, 0)};
        run_prog("R2 link write stall", 3);
        prog = '{ii(6'h17, 0, 0, 0), ii(6'h2B, 0, 31, 0)};
        run_prog("R2 R5 link via register then store", 3);
        // R2: register ALU writes rd, not rt
        prog = '{rr(3, 0, 9), rr(10, 9, 0)};
        run_prog("R2 rd is destination", 0);
        // R4: jump and jump-and-link ignore the rs field
        prog = '{ii(6'h23, 0, 5, 0), {6'h02, 5'd5, 21'h0}, {6'h03, 5'd5, 21'h0}};
        run_prog("R4 jump rs ignored", 0);
        prog = '{ii(6'h23, 0, 4, 0), {6'h16, 5'd4, 21'h0}};
        run_prog("R4 jump register reads rs", 3);
        // R6: two producers, both sources pending
        prog = '{rr(1, 0, 0), rr(2, 0, 0), rr(3, 1, 2)};
        run_prog("R6 two producers", 3);
        // R10: store then load to same address
        prog = '{ii(6'h2B, 1, 2, 7), ii(6'h23, 3, 4, 5)};
        run_prog("R10 memory dependence", 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule